// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator with Set/Clear Enable Mask

This block gathers up to sixteen external interrupt request lines into one active-high, level-sensitive request to a host processor. Each source line is first brought into the local clock domain by a two-flop synchroniser. Its synchronised level then sets a sticky pending bit. A pending bit is set whether or not its source is enabled. A separate enable mask decides which pending bits may drive the host request line.

Software reaches the block over a small synchronous 16-bit register port with four word locations:
- The pending-status word is write-one-to-clear.
- A raw view shows the synchronised input levels as they are now.
- The enable mask has no plain write. It is changed only through a write-one-to-set location and a write-one-to-clear location, and either location reads back the current mask.

A service routine reads the pending word and the mask, ANDs them, handles each source that is set, and writes ones back to the pending word to acknowledge. At start-up, writing all ones to the mask-clear location and then to the pending word leaves every source disabled and nothing pending.

Top module: `irq_fanin`

## Requirements
- R1: After reset the enable mask and the pending word are all zeros, the host request `parentIrq` is low and `busRdata` is zero.
- R2: Bit n of the pending word is set on every clock in which synchronised source n is high, whatever the mask holds. A source held high for at least one clock is captured. It appears in the pending word by the third rising edge after the input changes.
- R3: A read at byte offset 0x18 returns the synchronised source levels of that moment, bit n for source n. It does not return the latched pending bits.
- R4: At offset 0x1A, each 1 in a written word sets the corresponding mask bit. At offset 0x1C, each 1 clears it. A 0 leaves that mask bit unchanged at either location. A read at either 0x1A or 0x1C returns the current mask.
- R5: `parentIrq` is high exactly while some bit is 1 in both the pending word and the mask. A pending bit whose mask bit is 0 does not raise it.
- R6: At offset 0x16, each 1 in a written word clears that pending bit and a 0 leaves it unchanged. If the source is still high at the edge of that write, the bit stays set. A read at 0x16 returns the pending word.
- R7: Writing 0xFFFF to offset 0x1C and then 0xFFFF to offset 0x16, with all sources low, leaves the mask and the pending word at zero and `parentIrq` low. This holds whatever state the block was in before.
- R8: Read data is registered. It is valid on `busRdata` after the rising edge at which `busRd` is sampled high, and it holds until the next read strobe.
- R9: A read at any byte offset other than 0x16, 0x18, 0x1A and 0x1C returns zero. This includes odd offsets inside the mapped range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | 16 | Asynchronous interrupt source lines, bit n is source n |
| busAddr | input | 8 | Byte offset of the register access |
| busWr | input | 1 | Write strobe, one clock per write |
| busRd | input | 1 | Read strobe, one clock per read |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| parentIrq | output | 1 | Active-high level request to the host |

## Verification
The bench holds a source high through an acknowledge write. A design in which the clear beat the set would lose that still-active request. A source that pulses while it is masked must still be latched and must raise the request once it is enabled; a design that gated latching with the mask would drop that interrupt silently. Mask writes that contain zero bits, and reads of the mask through the clear location, show whether a design treats either location as a plain overwrite. The test also uses sources 0 and 15 and unmapped or odd offsets, to catch decode and edge-bit faults.

// File: rtl/irq_fanin_pkg.sv
package irq_fanin_pkg;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_RAW    = 2'd2,
    SEL_MASK   = 2'd3
  } regSelE;

  // Strobes from the bus decoder into the datapath
  typedef struct packed {
    logic   wrStatus;
    logic   wrMaskSet;
    logic   wrMaskClr;
    logic   rdEn;
    regSelE rdSel;
  } ctrlStrbS;

endpackage

// File: rtl/irq_fanin_sync.sv
module irq_fanin_sync #(
  parameter int NUM_SRC = 16,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] asyncIn,
  output logic [NUM_SRC-1:0] syncOut
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_bit
      logic [STAGES-1:0] chainQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= '0;
        else       chainQ <= {chainQ[STAGES-2:0], asyncIn[gi]};
      end
      assign syncOut[gi] = chainQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl
  import irq_fanin_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h16,
  parameter logic [ADDR_W-1:0] OFS_RAW    = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_MSET   = 8'h1A,
  parameter logic [ADDR_W-1:0] OFS_MCLR   = 8'h1C
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output ctrlStrbS          strb
);

  always_comb begin
    strb.wrStatus  = busWr && (busAddr == OFS_STATUS);
    strb.wrMaskSet = busWr && (busAddr == OFS_MSET);
    strb.wrMaskClr = busWr && (busAddr == OFS_MCLR);
    strb.rdEn      = busRd;
    if (busAddr == OFS_STATUS)                           strb.rdSel = SEL_STATUS;
    else if (busAddr == OFS_RAW)                         strb.rdSel = SEL_RAW;
    else if (busAddr == OFS_MSET || busAddr == OFS_MCLR) strb.rdSel = SEL_MASK;
    else                                                 strb.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/irq_fanin_dp.sv
module irq_fanin_dp
  import irq_fanin_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrbS           strb,
  input  logic [NUM_SRC-1:0] syncIn,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic               parentIrq
);

  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] ackBits;
  logic [NUM_SRC-1:0] setBits;
  logic [NUM_SRC-1:0] clrBits;

  assign ackBits = strb.wrStatus  ? wdata : '0;
  assign setBits = strb.wrMaskSet ? wdata : '0;
  assign clrBits = strb.wrMaskClr ? wdata : '0;

  // Sticky pending bits: a live source wins over an acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~ackBits) | syncIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else       maskQ <= (maskQ | setBits) & ~clrBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        SEL_STATUS: rdata <= statusQ;
        SEL_RAW:    rdata <= syncIn;
        SEL_MASK:   rdata <= maskQ;
        default:    rdata <= '0;
      endcase
    end
  end

  assign parentIrq = |(statusQ & maskQ);

  AST_SRC_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(syncIn)) == $past(syncIn))); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(syncIn)) == '0)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStatus |=> ((statusQ & $past(wdata) & ~$past(syncIn)) == '0)); // R6
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskSet |=> ((maskQ & $past(wdata)) == $past(wdata))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskClr |=> ((maskQ & $past(wdata)) == '0)); // R4
  AST_PARENT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parentIrq) |-> $past(strb.wrStatus || strb.wrMaskClr)); // R5

endmodule

// File: rtl/irq_fanin.sv
module irq_fanin
  import irq_fanin_pkg::*;
#(
  parameter int                NUM_SRC    = 16,
  parameter int                ADDR_W     = 8,
  parameter int                SYNC_STG   = 2,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h16,
  parameter logic [ADDR_W-1:0] OFS_RAW    = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_MSET   = 8'h1A,
  parameter logic [ADDR_W-1:0] OFS_MCLR   = 8'h1C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic               parentIrq
);

  logic [NUM_SRC-1:0] syncSrc;
  ctrlStrbS           strb;

  irq_fanin_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STG)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(srcIn), .syncOut(syncSrc)
  );

  irq_fanin_ctrl #(
    .ADDR_W(ADDR_W), .OFS_STATUS(OFS_STATUS), .OFS_RAW(OFS_RAW),
    .OFS_MSET(OFS_MSET), .OFS_MCLR(OFS_MCLR)
  ) ctrl_i (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .strb(strb)
  );

  irq_fanin_dp #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .syncIn(syncSrc),
    .wdata(busWdata), .rdata(busRdata), .parentIrq(parentIrq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (busRdata == '0 && !parentIrq)); // R1

endmodule

// File: tb/irq_fanin_tb.sv
module irq_fanin_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] srcIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        parentIrq;

  int vecCnt = 0;
  int errCnt = 0;
  bit summaryDone = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  irq_fanin dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .parentIrq(parentIrq)
  );

  task automatic report();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    end
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  // Driver: issue read strobe and push the expected value
  task automatic busRead(logic [7:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic drainWait();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // Monitor: data is valid after the edge that sampled busRd (R8)
  initial begin
    forever begin
      @(posedge clk);
      if (busRd && rstN) begin
        @(negedge clk);
        if (expQ.size() != 0) begin
          chk(tagQ.pop_front(), busRdata, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 readdata after reset", busRdata, 16'h0000);
    chk("R1 parent after reset", {15'd0, parentIrq}, 16'h0000);
    rstN = 1'b1;
    idle(2);
    busRead(8'h16, 16'h0000, "R1 status after reset");
    busRead(8'h1A, 16'h0000, "R1 mask after reset");
    busRead(8'h18, 16'h0000, "R3 raw idle");

    busWrite(8'h1C, 16'hFFFF);
    busWrite(8'h16, 16'hFFFF);
    busRead(8'h16, 16'h0000, "R7 status after init");
    busRead(8'h1C, 16'h0000, "R7 mask after init");

    // Masked pulse on source 3 is still latched
    @(negedge clk); srcIn = 16'h0008;
    idle(2);
    @(negedge clk); srcIn = 16'h0000;
    idle(4);
    busRead(8'h16, 16'h0008, "R2 masked pulse latched");
    chk("R5 parent low while masked", {15'd0, parentIrq}, 16'h0000);
    busRead(8'h18, 16'h0000, "R3 raw shows no latched bit");

    @(negedge clk); srcIn = 16'h0020;
    idle(4);
    busRead(8'h18, 16'h0020, "R3 raw shows live source 5");
    busRead(8'h16, 16'h0028, "R2 status accumulates");

    busWrite(8'h1A, 16'h0008);
    busRead(8'h1A, 16'h0008, "R4 mask via set offset");
    busRead(8'h1C, 16'h0008, "R4 mask via clear offset");
    drainWait();
    chk("R5 parent high on enabled pending", {15'd0, parentIrq}, 16'h0001);

    busWrite(8'h16, 16'h0020);
    busRead(8'h16, 16'h0028, "R6 live source wins over ack");
    busWrite(8'h16, 16'h0000);
    busRead(8'h16, 16'h0028, "R6 zero ack bits no effect");
    busWrite(8'h16, 16'h0008);
    busRead(8'h16, 16'h0020, "R6 ack clears bit 3");
    drainWait();
    chk("R5 parent low with only masked pending", {15'd0, parentIrq}, 16'h0000);

    busWrite(8'h1A, 16'h0001);
    busRead(8'h1A, 16'h0009, "R4 set keeps other bits");
    busWrite(8'h1C, 16'h0008);
    busRead(8'h1A, 16'h0001, "R4 clear keeps other bits");
    busWrite(8'h1A, 16'h0020);
    drainWait();
    chk("R5 parent high after enabling bit 5", {15'd0, parentIrq}, 16'h0001);
    busWrite(8'h1C, 16'h0000);
    busRead(8'h1C, 16'h0021, "R4 zero clear word no effect");

    @(negedge clk); srcIn = 16'h0000;
    idle(4);
    busWrite(8'h16, 16'hFFFF);
    drainWait();
    chk("R6 parent low after full ack", {15'd0, parentIrq}, 16'h0000);
    busRead(8'h16, 16'h0000, "R6 status empty after full ack");

    busRead(8'h00, 16'h0000, "R9 offset 0x00");
    busRead(8'h1E, 16'h0000, "R9 offset 0x1E");
    busRead(8'h17, 16'h0000, "R9 odd offset 0x17");

    // Read data holds between strobes
    busRead(8'h1A, 16'h0021, "R8 mask read");
    idle(3);
    chk("R8 read data held", busRdata, 16'h0021);

    // Edge sources 0 and 15
    @(negedge clk); srcIn = 16'h8001;
    idle(2);
    @(negedge clk); srcIn = 16'h0000;
    idle(4);
    busRead(8'h16, 16'h8001, "R2 edge sources latched");
    busWrite(8'h1C, 16'h7FFE);
    busWrite(8'h1A, 16'h8000);
    busRead(8'h1C, 16'h8001, "R4 edge mask bits");
    busWrite(8'h16, 16'h8000);
    busRead(8'h16, 16'h0001, "R6 ack source 15");
    drainWait();
    chk("R5 parent from source 0", {15'd0, parentIrq}, 16'h0001);

    // Init sequence from a busy state
    busWrite(8'h1A, 16'hFFFF);
    busWrite(8'h1C, 16'hFFFF);
    busWrite(8'h16, 16'hFFFF);
    busRead(8'h16, 16'h0000, "R7 status cleared from busy state");
    busRead(8'h1A, 16'h0000, "R7 mask cleared from busy state");
    drainWait();
    chk("R7 parent low after init", {15'd0, parentIrq}, 16'h0000);

    idle(2);
    report();
    $finish;
  end

endmodule